// File: doc/BRIEF.md
# DDR2 Bank Row Tracker and Command Sequencer

This block sits between a request scheduler and the DDR2 command pins. It remembers, for every SDRAM bank, whether a row is open and which one. Each accepted request (read, write or close-all) becomes the shortest legal chain of DDR2 commands. A read or write to a bank whose open row differs first closes that bank with a single-bank precharge. A closed bank is opened with an activate. The column read or write follows. Rows are left open once the access is done, so a later access to the same row costs one column command.

Spacing between commands comes from run-time timing inputs. The gap from an activate to a column command in the same bank, the gap from a precharge to the next activate of that bank, and the gap between activates to any bank are each programmable. Column commands are held four clocks apart, which is one burst of eight beats. Two window outputs mark the clocks in which burst data is due on the bus: read data starts CAS latency clocks after the read command, and write data starts one clock earlier than that. No more than one command goes out per clock. A clock with nothing to send carries the no-operation encoding.

Requests arrive on a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the last command of that request has been sent. While ready is low the source must hold its request steady, and the block does not look at it.

Top module: `ddr_bank_seq`

## Requirements
- R1: During and right after reset the command pins carry the no-operation encoding, `req_ready` is high and both data windows are low.
- R2: A read (req_op 0) or write (req_op 1) to a bank whose open row equals the requested row produces one column command. Read is ras_n=1, cas_n=0, we_n=1 and write is ras_n=1, cas_n=0, we_n=0. The column is on addr[9:0], addr[10] is 0 and the bank is on mem_ba.
- R3: A read or write to a closed bank first issues an activate (ras_n=0, cas_n=1, we_n=1) with the row on mem_addr and the bank on mem_ba, and then the column command.
- R4: A read or write to a bank with a different open row issues a precharge (ras_n=0, cas_n=1, we_n=0, addr[10]=0) to that bank, then an activate, then the column command. Rows open in other banks are not affected.
- R5: A row stays open after its access. A later access to it needs no precharge or activate.
- R6: A column command follows the activate of its bank by at least cfg_trcd clocks. When nothing else delays it, the gap is exactly cfg_trcd.
- R7: Two activates, to any banks, are at least cfg_trrd+1 clocks apart. When nothing else delays the second one, the gap is exactly cfg_trrd+1.
- R8: An activate follows a precharge of its bank by at least cfg_trp clocks. When nothing else delays it, the gap is exactly cfg_trp.
- R9: Two column commands are at least 4 clocks apart (one 8-beat burst). The gap is exactly 4 when the second one was waiting.
- R10: A close-all request (req_op 2) issues one command with ras_n=0, cas_n=1, we_n=0 and addr[10]=1. After it every bank counts as closed.
- R11: rd_win is high from cfg_cl through cfg_cl+3 clocks after a read command. wr_win is high from cfg_cl-1 through cfg_cl+2 clocks after a write command.
- R12: A request is accepted only on a clock where req_valid and req_ready are both high. After acceptance req_ready is low until the last command of the request has been sent. A request held while ready is low is accepted once, after the previous request completes.
- R13: A clock with no command carries ras_n=cas_n=we_n=1 with mem_addr and mem_ba at zero. At most one command is sent per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_trcd | input | 4 | Activate-to-column spacing in clocks |
| cfg_trp | input | 4 | Precharge-to-activate spacing in clocks |
| cfg_trrd | input | 4 | Activate-to-activate spacing minus one |
| cfg_cl | input | 3 | CAS latency, 2 to 5 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_op | input | 2 | 0 read, 1 write, 2 close all banks |
| req_bank | input | 3 | Target bank |
| req_row | input | 13 | Target row |
| req_col | input | 10 | Target column |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | 3 | Bank address |
| mem_addr | output | 13 | Row, column or precharge-scope address |
| rd_win | output | 1 | Read data due on the bus this clock |
| wr_win | output | 1 | Write data due on the bus this clock |

## Verification
The bench uses the default build: eight banks, 13-bit rows, 10-bit columns, 4-bit timing fields and a largest CAS latency of 5. With these it can reach bank 7, the all-ones row 8191 and the all-ones column 1023. At run time it switches the timing inputs between short settings (activate-to-column 1 or 3, precharge gap 2) and long ones (precharge gap 5, activate spacing field 4). It also drives CAS latencies 3, 5 and 2. This shows that every gap and both windows follow the inputs and not fixed constants. The long activate spacing and precharge gap are longer than the bench's own hand-off delay, so the exact lower bounds can be seen at the pins.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_RD,
    CMD_WR,
    CMD_PRE,
    CMD_PALL
  } cmd_e;

  typedef enum logic [1:0] {
    OP_RD   = 2'd0,
    OP_WR   = 2'd1,
    OP_PALL = 2'd2,
    OP_RSV  = 2'd3
  } op_e;

  // {ras_n, cas_n, we_n} for each command
  function automatic logic [2:0] cmd_pins(cmd_e c);
    case (c)
      CMD_ACT:  return 3'b011;
      CMD_RD:   return 3'b101;
      CMD_WR:   return 3'b100;
      CMD_PRE:  return 3'b010;
      CMD_PALL: return 3'b010;
      default:  return 3'b111;
    endcase
  endfunction
endpackage

// File: rtl/ddr_gap_timer.sv
module ddr_gap_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         ok
);
  timeunit 1ns;
  timeprecision 100ps;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign ok = (cnt_q == '0);
endmodule

// File: rtl/ddr_bank_table.sv
module ddr_bank_table #(
  parameter int NB = 8,
  parameter int RW = 13,
  localparam int BW = $clog2(NB)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   act_en,
  input  logic                   pre_en,
  input  logic                   pall_en,
  input  logic [BW-1:0]          sel,
  input  logic [RW-1:0]          row_in,
  output logic [NB-1:0]          open_vec,
  output logic [NB-1:0][RW-1:0]  rows
);
  timeunit 1ns;
  timeprecision 100ps;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic          open_q;
    logic [RW-1:0] row_q;
    wire           mine = (sel == BW'(b));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_q <= 1'b0;
        row_q  <= '0;
      end else if (pall_en || (pre_en && mine)) begin
        open_q <= 1'b0;
      end else if (act_en && mine) begin
        open_q <= 1'b1;
        row_q  <= row_in;
      end
    end

    assign open_vec[b] = open_q;
    assign rows[b]     = row_q;
  end
endmodule

// File: rtl/ddr_lat_window.sv
module ddr_lat_window #(
  parameter int DEPTH = 9,
  parameter int LW    = 3,
  parameter int SPAN  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [LW-1:0] lat,
  output logic          win
);
  timeunit 1ns;
  timeprecision 100ps;

  // pipe[k] set: a command went out k clocks ago
  logic [DEPTH-1:0] pipe;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[DEPTH-2:0], fire};
  end

  always_comb begin
    win = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      if (pipe[k] && (k >= int'(lat)) && (k < int'(lat) + SPAN)) win = 1'b1;
    end
  end
endmodule

// File: rtl/ddr_bank_seq.sv
module ddr_bank_seq
  import ddr_seq_pkg::*;
#(
  parameter int NB    = 8,
  parameter int RW    = 13,
  parameter int CW    = 10,
  parameter int TW    = 4,
  parameter int BL    = 8,
  parameter int MAXCL = 5,
  localparam int BW     = $clog2(NB),
  localparam int AP_BIT = 10,
  localparam int BCLK   = BL / 2,
  localparam int DEPTH  = MAXCL + BCLK
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] cfg_trcd,
  input  logic [TW-1:0] cfg_trp,
  input  logic [TW-1:0] cfg_trrd,
  input  logic [2:0]    cfg_cl,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [BW-1:0] req_bank,
  input  logic [RW-1:0] req_row,
  input  logic [CW-1:0] req_col,
  output logic          mem_ras_n,
  output logic          mem_cas_n,
  output logic          mem_we_n,
  output logic [BW-1:0] mem_ba,
  output logic [RW-1:0] mem_addr,
  output logic          rd_win,
  output logic          wr_win
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam logic [TW-1:0] CCD_LOAD = TW'(BCLK - 1);

  // held request
  logic          busy_q;
  op_e           h_op;
  logic [BW-1:0] h_bank;
  logic [RW-1:0] h_row;
  logic [CW-1:0] h_col;

  wire accept = req_valid && !busy_q;
  assign req_ready = !busy_q;

  // bank state and timers
  logic [NB-1:0]         open_vec;
  logic [NB-1:0][RW-1:0] rows;
  logic [NB-1:0]         trcd_ok, trp_ok;
  logic                  rrd_ok, ccd_ok;

  cmd_e nxt;
  logic done;
  wire  hit = open_vec[h_bank] && (rows[h_bank] == h_row);

  always_comb begin
    nxt  = CMD_NOP;
    done = 1'b0;
    if (busy_q) begin
      if (h_op == OP_PALL) begin
        nxt  = CMD_PALL;
        done = 1'b1;
      end else if (hit) begin
        if (trcd_ok[h_bank] && ccd_ok) begin
          nxt  = (h_op == OP_WR) ? CMD_WR : CMD_RD;
          done = 1'b1;
        end
      end else if (open_vec[h_bank]) begin
        nxt = CMD_PRE;
      end else if (trp_ok[h_bank] && rrd_ok) begin
        nxt = CMD_ACT;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      h_op   <= OP_RD;
      h_bank <= '0;
      h_row  <= '0;
      h_col  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      h_op   <= op_e'(req_op);
      h_bank <= req_bank;
      h_row  <= req_row;
      h_col  <= req_col;
    end else if (done) begin
      busy_q <= 1'b0;
    end
  end

  // command output register
  cmd_e          cmd_q;
  logic [BW-1:0] ba_q;
  logic [RW-1:0] addr_q;
  logic [RW-1:0] col_addr;

  always_comb begin
    col_addr           = '0;
    col_addr[CW-1:0]   = h_col;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
    end else begin
      cmd_q <= nxt;
      case (nxt)
        CMD_ACT: begin
          ba_q   <= h_bank;
          addr_q <= h_row;
        end
        CMD_RD, CMD_WR: begin
          ba_q   <= h_bank;
          addr_q <= col_addr;
        end
        CMD_PRE: begin
          ba_q   <= h_bank;
          addr_q <= '0;
        end
        CMD_PALL: begin
          ba_q   <= '0;
          addr_q <= RW'(1) << AP_BIT;
        end
        default: begin
          ba_q   <= '0;
          addr_q <= '0;
        end
      endcase
    end
  end

  assign {mem_ras_n, mem_cas_n, mem_we_n} = cmd_pins(cmd_q);
  assign mem_ba   = ba_q;
  assign mem_addr = addr_q;

  // open-row table
  ddr_bank_table #(.NB(NB), .RW(RW)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .act_en   (nxt == CMD_ACT),
    .pre_en   (nxt == CMD_PRE),
    .pall_en  (nxt == CMD_PALL),
    .sel      (h_bank),
    .row_in   (h_row),
    .open_vec (open_vec),
    .rows     (rows)
  );

  // spacing timers: load value = gap - 1
  wire [TW-1:0] trcd_load = (cfg_trcd == '0) ? '0 : cfg_trcd - 1'b1;
  wire [TW-1:0] trp_load  = (cfg_trp  == '0) ? '0 : cfg_trp  - 1'b1;

  for (genvar b = 0; b < NB; b++) begin : g_tmr
    wire sel_b = (h_bank == BW'(b));

    ddr_gap_timer #(.W(TW)) u_trcd (
      .clk   (clk),
      .rst_n (rst_n),
      .load  ((nxt == CMD_ACT) && sel_b),
      .val   (trcd_load),
      .ok    (trcd_ok[b])
    );

    ddr_gap_timer #(.W(TW)) u_trp (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (((nxt == CMD_PRE) && sel_b) || (nxt == CMD_PALL)),
      .val   (trp_load),
      .ok    (trp_ok[b])
    );
  end

  ddr_gap_timer #(.W(TW)) u_rrd (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (nxt == CMD_ACT),
    .val   (cfg_trrd),
    .ok    (rrd_ok)
  );

  ddr_gap_timer #(.W(TW)) u_ccd (
    .clk   (clk),
    .rst_n (rst_n),
    .load  ((nxt == CMD_RD) || (nxt == CMD_WR)),
    .val   (CCD_LOAD),
    .ok    (ccd_ok)
  );

  // data windows
  ddr_lat_window #(.DEPTH(DEPTH), .LW(3), .SPAN(BCLK)) u_rdwin (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (nxt == CMD_RD),
    .lat   (cfg_cl),
    .win   (rd_win)
  );

  ddr_lat_window #(.DEPTH(DEPTH), .LW(3), .SPAN(BCLK)) u_wrwin (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (nxt == CMD_WR),
    .lat   (cfg_cl - 3'd1),
    .win   (wr_win)
  );
endmodule

// File: rtl/ddr_bank_seq_chk.sv
module ddr_bank_seq_chk #(
  parameter int TW = 4,
  parameter int RW = 13,
  parameter int BW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          ras_n,
  input logic          cas_n,
  input logic          we_n,
  input logic [BW-1:0] ba,
  input logic [RW-1:0] addr,
  input logic [TW-1:0] cfg_trrd
);
  timeunit 1ns;
  timeprecision 100ps;

  wire act_now  = !ras_n && cas_n && we_n;
  wire col_now  = ras_n && !cas_n;
  wire pall_now = !ras_n && cas_n && !we_n && addr[10];
  wire nop_now  = ras_n && cas_n && we_n;

  logic [7:0] since_act, since_col;
  logic       all_closed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_act  <= '0;
      since_col  <= '0;
      all_closed <= 1'b1;
    end else begin
      if (act_now)                 since_act <= 8'd1;
      else if (since_act != 8'd0 && since_act != 8'hff) since_act <= since_act + 8'd1;
      if (col_now)                 since_col <= 8'd1;
      else if (since_col != 8'd0 && since_col != 8'hff) since_col <= since_col + 8'd1;
      if (pall_now)                all_closed <= 1'b1;
      else if (act_now)            all_closed <= 1'b0;
    end
  end

  // R12
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R7
  act_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_now && since_act != 8'd0) |-> (since_act >= 8'(cfg_trrd) + 8'd1));

  // R9
  col_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_now && since_col != 8'd0) |-> (since_col >= 8'd4));

  // R10
  closed_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_now |-> !all_closed);

  // R13
  nop_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nop_now |-> (addr == '0 && ba == '0));
endmodule

bind ddr_bank_seq ddr_bank_seq_chk #(.TW(TW), .RW(RW), .BW(BW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .ras_n     (mem_ras_n),
  .cas_n     (mem_cas_n),
  .we_n      (mem_we_n),
  .ba        (mem_ba),
  .addr      (mem_addr),
  .cfg_trrd  (cfg_trrd)
);

// File: tb/ddr_bank_seq_test.sv
module ddr_bank_seq_test;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_trcd, cfg_trp, cfg_trrd;
  logic [2:0]  cfg_cl;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = '0;
  logic [2:0]  req_bank = '0;
  logic [12:0] req_row = '0;
  logic [9:0]  req_col = '0;
  logic        mem_ras_n, mem_cas_n, mem_we_n;
  logic [2:0]  mem_ba;
  logic [12:0] mem_addr;
  logic        rd_win, wr_win;

  ddr_bank_seq uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_trcd(cfg_trcd), .cfg_trp(cfg_trp), .cfg_trrd(cfg_trrd), .cfg_cl(cfg_cl),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
    .mem_ba(mem_ba), .mem_addr(mem_addr), .rd_win(rd_win), .wr_win(wr_win)
  );

  always #2.5 clk = ~clk;

  // bench command codes
  localparam int K_NOP = 0, K_ACT = 1, K_RD = 2, K_WR = 3, K_PRE = 4, K_PALL = 5, K_BAD = 7;

  int nchk = 0, nfail = 0, cyc = 0;
  bit ended = 1'b0;

  int lg_kind [0:511];
  int lg_ba   [0:511];
  int lg_addr [0:511];
  int lg_cyc  [0:511];
  int lg_n = 0;
  bit rd_hist [0:4095];
  bit wr_hist [0:4095];
  int last_act [0:7];
  int last_pre [0:7];
  int last_act_any = -100, last_col = -100;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  function automatic int decode();
    case ({mem_ras_n, mem_cas_n, mem_we_n})
      3'b111: return K_NOP;
      3'b011: return K_ACT;
      3'b101: return K_RD;
      3'b100: return K_WR;
      3'b010: return mem_addr[10] ? K_PALL : K_PRE;
      default: return K_BAD;
    endcase
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: log commands, check spacing lower bounds
  always @(negedge clk) begin
    if (rst_n) begin
      int k;
      k = decode();
      rd_hist[cyc % 4096] = rd_win;
      wr_hist[cyc % 4096] = wr_win;
      if (k != K_NOP) begin
        if (lg_n < 512) begin
          lg_kind[lg_n] = k; lg_ba[lg_n] = int'(mem_ba);
          lg_addr[lg_n] = int'(mem_addr); lg_cyc[lg_n] = cyc;
          lg_n++;
        end
        check(k != K_BAD, "R13 legal encoding", k, K_RD);
        case (k)
          K_ACT: begin
            check(cyc - last_act_any >= int'(cfg_trrd) + 1, "R7 act-act gap",
                  cyc - last_act_any, int'(cfg_trrd) + 1);
            check(cyc - last_pre[mem_ba] >= int'(cfg_trp), "R8 pre-act gap",
                  cyc - last_pre[mem_ba], int'(cfg_trp));
            last_act_any = cyc;
            last_act[mem_ba] = cyc;
          end
          K_PRE: last_pre[mem_ba] = cyc;
          K_PALL: for (int b = 0; b < 8; b++) last_pre[b] = cyc;
          K_RD, K_WR: begin
            check(cyc - last_act[mem_ba] >= int'(cfg_trcd), "R6 act-col gap",
                  cyc - last_act[mem_ba], int'(cfg_trcd));
            check(cyc - last_col >= 4, "R9 col-col gap", cyc - last_col, 4);
            last_col = cyc;
          end
          default: ;
        endcase
      end
    end
  end

  task automatic send(input int op, input int b, input int row, input int col);
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op); req_bank = 3'(b);
    req_row = 13'(row); req_col = 10'(col);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    #1;
  endtask

  task automatic chk_cmd(input int idx, input int kind, input int ba, input int addr, input string tag);
    check(lg_kind[idx] == kind, {tag, " kind"}, lg_kind[idx], kind);
    check(lg_ba[idx] == ba, {tag, " bank"}, lg_ba[idx], ba);
    check(lg_addr[idx] == addr, {tag, " addr"}, lg_addr[idx], addr);
  endtask

  // {kind(2), op(2), bank(3), row(13), col(10)}; kind 0 hit, 1 closed, 2 conflict, 3 close-all
  localparam logic [29:0] VEC [0:11] = '{
    {2'd1, 2'd0, 3'd0, 13'd5,    10'd8},
    {2'd0, 2'd0, 3'd0, 13'd5,    10'd16},
    {2'd1, 2'd1, 3'd1, 13'd7,    10'd4},
    {2'd0, 2'd1, 3'd0, 13'd5,    10'd24},
    {2'd2, 2'd0, 3'd0, 13'd9,    10'd3},
    {2'd0, 2'd0, 3'd1, 13'd7,    10'd5},
    {2'd1, 2'd1, 3'd7, 13'd8191, 10'd1023},
    {2'd0, 2'd1, 3'd7, 13'd8191, 10'd0},
    {2'd3, 2'd2, 3'd0, 13'd0,    10'd0},
    {2'd1, 2'd0, 3'd1, 13'd7,    10'd5},
    {2'd1, 2'd0, 3'd0, 13'd9,    10'd1},
    {2'd0, 2'd0, 3'd0, 13'd9,    10'd2}
  };

  initial begin
    #(5.0 * 150000);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int s, cnt, colk, c;
    for (int b = 0; b < 8; b++) begin last_act[b] = -100; last_pre[b] = -100; end
    cfg_trcd = 4'd3; cfg_trp = 4'd2; cfg_trrd = 4'd1; cfg_cl = 3'd3;

    // R1: reset state
    repeat (3) @(negedge clk);
    check({mem_ras_n, mem_cas_n, mem_we_n} == 3'b111, "R1 nop during reset",
          int'({mem_ras_n, mem_cas_n, mem_we_n}), 7);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    check(rd_win == 1'b0 && wr_win == 1'b0, "R1 windows low", int'({rd_win, wr_win}), 0);
    check(mem_addr == '0 && mem_ba == '0, "R1 address zero", int'(mem_addr), 0);

    // table walk: R2 R3 R4 R5 R6 R8 R9 R10
    for (int i = 0; i < 12; i++) begin
      int kind, op, bk, row, col;
      {kind, op, bk, row, col} = {30'd0, 2'd0, 2'd0, 3'd0, 13'd0, 10'd0};
      kind = int'(VEC[i][29:28]); op = int'(VEC[i][27:26]); bk = int'(VEC[i][25:23]);
      row = int'(VEC[i][22:10]); col = int'(VEC[i][9:0]);
      s = lg_n;
      send(op, bk, row, col);
      cnt = lg_n - s;
      colk = (op == 1) ? K_WR : K_RD;
      case (kind)
        0: begin
          check(cnt == 1, "R5 hit needs one command", cnt, 1);
          chk_cmd(s, colk, bk, col, "R2 column");
          check(lg_cyc[s] - lg_cyc[s-1] == 4, "R9 waiting col gap exact",
                lg_cyc[s] - lg_cyc[s-1], 4);
        end
        1: begin
          check(cnt == 2, "R3 closed bank count", cnt, 2);
          chk_cmd(s, K_ACT, bk, row, "R3 activate");
          chk_cmd(s + 1, colk, bk, col, "R3 column");
          check(lg_cyc[s+1] - lg_cyc[s] == 3, "R6 act-col exact",
                lg_cyc[s+1] - lg_cyc[s], 3);
        end
        2: begin
          check(cnt == 3, "R4 conflict count", cnt, 3);
          chk_cmd(s, K_PRE, bk, 0, "R4 precharge");
          chk_cmd(s + 1, K_ACT, bk, row, "R4 activate");
          chk_cmd(s + 2, colk, bk, col, "R4 column");
          check(lg_cyc[s+1] - lg_cyc[s] == 2, "R8 pre-act exact",
                lg_cyc[s+1] - lg_cyc[s], 2);
        end
        default: begin
          check(cnt == 1, "R10 close-all count", cnt, 1);
          chk_cmd(s, K_PALL, 0, 1024, "R10 close-all");
        end
      endcase
    end

    // R13: idle clocks carry NOP with zero address
    repeat (3) @(negedge clk);
    check({mem_ras_n, mem_cas_n, mem_we_n} == 3'b111 && mem_addr == '0 && mem_ba == '0,
          "R13 idle nop", int'(mem_addr), 0);

    // R7: activate spacing exact with field 4
    cfg_trcd = 4'd1; cfg_trrd = 4'd4;
    s = lg_n;
    send(0, 2, 1, 0);
    send(0, 3, 2, 0);
    check(lg_n - s == 4, "R7 two-bank count", lg_n - s, 4);
    check(lg_kind[s] == K_ACT && lg_kind[s+2] == K_ACT, "R7 two activates", lg_kind[s+2], K_ACT);
    check(lg_cyc[s+2] - lg_cyc[s] == 5, "R7 act-act exact", lg_cyc[s+2] - lg_cyc[s], 5);

    // R8: precharge gap exact with 5; R4 bank 3 stays open
    cfg_trcd = 4'd3; cfg_trp = 4'd5;
    s = lg_n;
    send(0, 2, 4, 6);
    check(lg_n - s == 3, "R4 conflict bank2 count", lg_n - s, 3);
    check(lg_cyc[s+1] - lg_cyc[s] == 5, "R8 pre-act exact long", lg_cyc[s+1] - lg_cyc[s], 5);
    s = lg_n;
    send(1, 3, 2, 9);
    check(lg_n - s == 1, "R4 other bank still open", lg_n - s, 1);

    // R11: read window with CL 5
    cfg_cl = 3'd5;
    repeat (10) @(negedge clk);
    s = lg_n;
    send(0, 2, 4, 7);
    c = lg_cyc[s];
    repeat (12) @(negedge clk);
    for (int k = 4; k <= 9; k++) begin
      bit exp;
      exp = (k >= 5 && k <= 8);
      check(rd_hist[(c + k) % 4096] == exp, "R11 read window", int'(rd_hist[(c + k) % 4096]), int'(exp));
    end
    // R11: write window with CL 2
    cfg_cl = 3'd2;
    s = lg_n;
    send(1, 2, 4, 8);
    c = lg_cyc[s];
    repeat (12) @(negedge clk);
    for (int k = 0; k <= 5; k++) begin
      bit exp;
      exp = (k >= 1 && k <= 4);
      check(wr_hist[(c + k) % 4096] == exp, "R11 write window", int'(wr_hist[(c + k) % 4096]), int'(exp));
      check(rd_hist[(c + k) % 4096] == 1'b0, "R11 no read window on write", int'(rd_hist[(c + k) % 4096]), 0);
    end

    // R12: request held under back-pressure is taken once
    s = lg_n;
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd0; req_bank = 3'd2; req_row = 13'd4; req_col = 10'd11;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    check(req_ready == 1'b0, "R12 ready low after accept", int'(req_ready), 0);
    req_col = 10'd12;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    repeat (10) @(negedge clk);
    check(lg_n - s == 2, "R12 held request taken once", lg_n - s, 2);
    check(lg_addr[s] == 11 && lg_addr[s+1] == 12, "R12 order kept", lg_addr[s+1], 12);

    finish_run();
  end
endmodule